// File: doc/BRIEF.md
# Multithreaded Fetch Slot Arbiter

The block sits in the front end of an eight-context simultaneously multithreaded core. In every cycle it decides which hardware threads may fetch and how many instruction slots each one gets out of a shared eight-wide fetch bundle. It keeps three saturating occupancy counters per thread: instructions fetched but not yet issued, unresolved branches in flight, and outstanding data cache misses. Pulses from fetch, issue, squash, branch resolution and miss handling move these counters up and down.

A static policy input selects the ranking. In rotation mode a single thread fetches the full bundle. In the three counter-driven modes the two eligible threads with the smallest value of the selected counter are granted four slots each. Ties are settled by a rotating pointer that steps once per cycle. A thread that is waiting on an instruction cache miss is not eligible. The grant is a combinational function of registered state, so counter updates made in one cycle first affect the grant in the next cycle.

Top module: `smt_fetch_pick`

## Requirements
- R1: After reset all counters read zero and the rotation pointer is at thread 0. In the first cycle after reset, with policy 1 and every thread eligible, threads 0 and 1 are granted in that order.
- R2: The rotation pointer advances by one thread every cycle and wraps from 7 to 0. In policy 0 with every thread eligible, the granted thread id therefore rises by one each cycle.
- R3: Each counter is 7 bits wide. It stays at 127 when pushed higher and stays at 0 when pushed lower.
- R4: When a counter gets increments and decrements in the same cycle, it moves by the net amount. The unissued counter goes up by one for a fetch pulse and down by one for each issue pulse and each squash pulse.
- R5: Policy 1 (mode_i = 2'd1) ranks eligible threads by fewest fetched-but-unissued instructions. Slot 0 gets the smallest count and slot 1 gets the next.
- R6: Policy 2 (mode_i = 2'd2) ranks eligible threads by fewest unresolved branches in flight.
- R7: Policy 3 (mode_i = 2'd3) ranks eligible threads by fewest outstanding data cache misses.
- R8: A thread whose icache_miss_i bit is set is never granted.
- R9: Policy 0 (mode_i = 2'd0) grants the first eligible thread at or after the rotation pointer. That thread gets a quota of 8, and slot 1 is invalid.
- R10: In a counter-driven policy with two or more eligible threads, both slots are valid, the two thread ids differ, and each quota is 4.
- R11: With exactly one eligible thread, only slot 0 is valid and its quota is 8. With no eligible thread, both valid outputs are low and both quotas are 0.
- R12: Equal counter values are ordered by distance from the rotation pointer: the thread at the pointer first, then the threads after it, wrapping around.
- R13: A counter update pulse in cycle N does not change the grant in cycle N. It takes effect in the grant of cycle N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Ranking policy: 0 rotation, 1 unissued, 2 branch, 3 data miss |
| icache_miss_i | input | 8 | Per-thread pending instruction cache miss; makes the thread ineligible |
| fetch_acc_i | input | 8 | Per-thread fetch accepted; unissued counter +1 |
| issue_i | input | 8 | Per-thread instruction issued; unissued counter -1 |
| squash_i | input | 8 | Per-thread instruction squashed; unissued counter -1 |
| br_fetch_i | input | 8 | Per-thread branch fetched; branch counter +1 |
| br_resolve_i | input | 8 | Per-thread branch resolved; branch counter -1 |
| dmiss_start_i | input | 8 | Per-thread data miss started; miss counter +1 |
| dmiss_done_i | input | 8 | Per-thread data miss returned; miss counter -1 |
| pick0_id_o | output | 3 | Thread granted in slot 0 |
| pick0_vld_o | output | 1 | Slot 0 grant valid |
| pick0_quota_o | output | 4 | Fetch slots for slot 0 |
| pick1_id_o | output | 3 | Thread granted in slot 1 |
| pick1_vld_o | output | 1 | Slot 1 grant valid |
| pick1_quota_o | output | 4 | Fetch slots for slot 1 |

## Verification
Two things can happen in one cycle: a counter update and a ranking that depends on that counter. The bench provokes this by pulsing fetch, issue and squash on a thread while a counter-driven policy is ranking it, and by holding a counter at 0 or 127 while opposing pulses arrive. It then checks that the grant seen before the clock edge still reflects the old count and that the next grant reflects the net, clamped count. The rotating pointer also moves in the same cycle as the counters, so tie ordering and counter ordering change together. A bench model that tracks all three counter banks and the pointer judges every cycle of random traffic under all four policies.

// File: rtl/smt_fetch_pkg.sv
package smt_fetch_pkg;
  typedef enum logic [1:0] {
    POL_RR       = 2'd0,
    POL_UNISSUED = 2'd1,
    POL_BRANCH   = 2'd2,
    POL_DMISS    = 2'd3
  } fetch_pol_e;
endpackage

// File: rtl/sat_ctr.sv
module sat_ctr #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         up_i,
  input  logic         dn_a_i,
  input  logic         dn_b_i,
  output logic [W-1:0] cnt_o
);
  localparam int MAX = (1 << W) - 1;

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    int v;
    v = int'(cnt_q) + int'(up_i) - int'(dn_a_i) - int'(dn_b_i);
    if (v < 0)        cnt_d = '0;
    else if (v > MAX) cnt_d = W'(MAX);
    else              cnt_d = W'(v);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/min_pick.sv
module min_pick #(
  parameter int N  = 8,
  parameter int KW = 10,
  localparam int TW = $clog2(N)
) (
  input  logic [N-1:0][KW-1:0] key_i,
  input  logic [N-1:0]         mask_i,
  output logic [TW-1:0]        idx_o,
  output logic                 found_o
);
  always_comb begin
    logic          hit;
    logic [KW-1:0] best;
    hit   = 1'b0;
    best  = '1;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (mask_i[i] && (!hit || key_i[i] < best)) begin
        hit   = 1'b1;
        best  = key_i[i];
        idx_o = TW'(i);
      end
    end
    found_o = hit;
  end
endmodule

// File: rtl/smt_fetch_pick.sv
module smt_fetch_pick
  import smt_fetch_pkg::*;
#(
  parameter int NUM_THR = 8,
  parameter int CNT_W   = 7,
  parameter int FETCH_W = 8,
  localparam int TW = $clog2(NUM_THR),
  localparam int QW = $clog2(FETCH_W + 1),
  localparam int KW = CNT_W + TW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         mode_i,
  input  logic [NUM_THR-1:0] icache_miss_i,
  input  logic [NUM_THR-1:0] fetch_acc_i,
  input  logic [NUM_THR-1:0] issue_i,
  input  logic [NUM_THR-1:0] squash_i,
  input  logic [NUM_THR-1:0] br_fetch_i,
  input  logic [NUM_THR-1:0] br_resolve_i,
  input  logic [NUM_THR-1:0] dmiss_start_i,
  input  logic [NUM_THR-1:0] dmiss_done_i,
  output logic [TW-1:0]      pick0_id_o,
  output logic               pick0_vld_o,
  output logic [QW-1:0]      pick0_quota_o,
  output logic [TW-1:0]      pick1_id_o,
  output logic               pick1_vld_o,
  output logic [QW-1:0]      pick1_quota_o
);
  fetch_pol_e mode;
  assign mode = fetch_pol_e'(mode_i);

  logic [NUM_THR-1:0][CNT_W-1:0] ic_cnt, br_cnt, ms_cnt, rank_cnt;
  logic [NUM_THR-1:0][KW-1:0]    key;
  logic [TW-1:0]                 ptr_q;
  logic [NUM_THR-1:0]            elig, mask1, first_oh;
  logic [TW-1:0]                 idx0, idx1;
  logic                          found0, found1;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    sat_ctr #(.W(CNT_W)) u_ic (
      .clk_i, .rst_ni,
      .up_i(fetch_acc_i[t]), .dn_a_i(issue_i[t]), .dn_b_i(squash_i[t]),
      .cnt_o(ic_cnt[t])
    );
    sat_ctr #(.W(CNT_W)) u_br (
      .clk_i, .rst_ni,
      .up_i(br_fetch_i[t]), .dn_a_i(br_resolve_i[t]), .dn_b_i(1'b0),
      .cnt_o(br_cnt[t])
    );
    sat_ctr #(.W(CNT_W)) u_ms (
      .clk_i, .rst_ni,
      .up_i(dmiss_start_i[t]), .dn_a_i(dmiss_done_i[t]), .dn_b_i(1'b0),
      .cnt_o(ms_cnt[t])
    );
  end

  // rotation pointer steps every cycle regardless of policy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    ptr_q <= '0;
    else if (ptr_q == TW'(NUM_THR - 1)) ptr_q <= '0;
    else                            ptr_q <= ptr_q + 1'b1;
  end

  always_comb begin
    for (int i = 0; i < NUM_THR; i++) begin
      unique case (mode)
        POL_UNISSUED: rank_cnt[i] = ic_cnt[i];
        POL_BRANCH:   rank_cnt[i] = br_cnt[i];
        POL_DMISS:    rank_cnt[i] = ms_cnt[i];
        default:      rank_cnt[i] = '0;
      endcase
      // low bits: distance from pointer breaks ties
      key[i] = {rank_cnt[i], TW'((i + NUM_THR - int'(ptr_q)) % NUM_THR)};
    end
  end

  assign elig     = ~icache_miss_i;
  assign first_oh = found0 ? (NUM_THR'(1) << idx0) : '0;
  assign mask1    = elig & ~first_oh;

  min_pick #(.N(NUM_THR), .KW(KW)) u_pick0 (
    .key_i(key), .mask_i(elig), .idx_o(idx0), .found_o(found0)
  );
  min_pick #(.N(NUM_THR), .KW(KW)) u_pick1 (
    .key_i(key), .mask_i(mask1), .idx_o(idx1), .found_o(found1)
  );

  assign pick0_id_o    = idx0;
  assign pick0_vld_o   = found0;
  assign pick1_id_o    = idx1;
  assign pick1_vld_o   = found1 && (mode != POL_RR);
  assign pick0_quota_o = !found0     ? '0 :
                         pick1_vld_o ? QW'(FETCH_W / 2) : QW'(FETCH_W);
  assign pick1_quota_o = pick1_vld_o ? QW'(FETCH_W / 2) : '0;
endmodule

// File: rtl/smt_fetch_pick_chk.sv
module smt_fetch_pick_chk #(
  parameter int NUM_THR = 8,
  parameter int CNT_W   = 7,
  parameter int FETCH_W = 8,
  localparam int TW = $clog2(NUM_THR),
  localparam int QW = $clog2(FETCH_W + 1)
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [1:0]                    mode_i,
  input logic [NUM_THR-1:0]            icache_miss_i,
  input logic [NUM_THR-1:0]            fetch_acc_i,
  input logic [NUM_THR-1:0]            issue_i,
  input logic [NUM_THR-1:0]            squash_i,
  input logic [NUM_THR-1:0][CNT_W-1:0] ic_cnt,
  input logic [TW-1:0]                 ptr_q,
  input logic [TW-1:0]                 pick0_id_o,
  input logic                          pick0_vld_o,
  input logic [QW-1:0]                 pick0_quota_o,
  input logic [TW-1:0]                 pick1_id_o,
  input logic                          pick1_vld_o,
  input logic [QW-1:0]                 pick1_quota_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  assert_ptr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ptr_q == (($past(ptr_q) == TW'(NUM_THR - 1)) ? '0 : $past(ptr_q) + 1'b1));

  assert_sat_hi_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ic_cnt[0] == CMAX && fetch_acc_i[0] && !issue_i[0] && !squash_i[0])
    |=> ic_cnt[0] == CMAX);

  assert_sat_lo_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ic_cnt[0] == '0 && !fetch_acc_i[0] && (issue_i[0] || squash_i[0]))
    |=> ic_cnt[0] == '0);

  assert_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 && pick1_vld_o) |-> ic_cnt[pick0_id_o] <= ic_cnt[pick1_id_o]);

  assert_no_miss_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pick0_vld_o |-> !icache_miss_i[pick0_id_o]);

  assert_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && pick0_vld_o) |-> (!pick1_vld_o && pick0_quota_o == QW'(FETCH_W)));

  assert_pair_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pick1_vld_o |-> (pick0_vld_o && pick0_id_o != pick1_id_o &&
                     pick0_quota_o == QW'(FETCH_W / 2) && pick1_quota_o == QW'(FETCH_W / 2)));

  assert_none_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&icache_miss_i) |-> (!pick0_vld_o && !pick1_vld_o && pick0_quota_o == '0));
endmodule

bind smt_fetch_pick smt_fetch_pick_chk #(
  .NUM_THR(NUM_THR), .CNT_W(CNT_W), .FETCH_W(FETCH_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .icache_miss_i(icache_miss_i),
  .fetch_acc_i(fetch_acc_i), .issue_i(issue_i), .squash_i(squash_i),
  .ic_cnt(ic_cnt), .ptr_q(ptr_q),
  .pick0_id_o(pick0_id_o), .pick0_vld_o(pick0_vld_o), .pick0_quota_o(pick0_quota_o),
  .pick1_id_o(pick1_id_o), .pick1_vld_o(pick1_vld_o), .pick1_quota_o(pick1_quota_o)
);

// File: tb/smt_fetch_pick_tb.sv
`timescale 1ns/1ps
module smt_fetch_pick_tb;
  localparam int N = 8;
  localparam int MAXC = 127;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] mode;
  logic [N-1:0] icm, fetch, issue, squash, brf, brr, dms, dmd;
  logic [2:0] id0, id1;
  logic v0, v1;
  logic [3:0] q0, q1;

  int m_ic[N], m_br[N], m_ms[N];
  int m_ptr;
  int n_chk = 0, n_fail = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  smt_fetch_pick u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .icache_miss_i(icm),
    .fetch_acc_i(fetch), .issue_i(issue), .squash_i(squash),
    .br_fetch_i(brf), .br_resolve_i(brr), .dmiss_start_i(dms), .dmiss_done_i(dmd),
    .pick0_id_o(id0), .pick0_vld_o(v0), .pick0_quota_o(q0),
    .pick1_id_o(id1), .pick1_vld_o(v1), .pick1_quota_o(q1)
  );

  function automatic int clampc(int v);
    if (v < 0) return 0;
    if (v > MAXC) return MAXC;
    return v;
  endfunction

  function automatic int rank_of(int t);
    case (mode)
      2'd1: return m_ic[t];
      2'd2: return m_br[t];
      2'd3: return m_ms[t];
      default: return 0;
    endcase
  endfunction

  task automatic clear_in();
    fetch = '0; issue = '0; squash = '0; brf = '0; brr = '0;
    dms = '0; dmd = '0; icm = '0;
  endtask

  task automatic check_now();
    int e_id0, e_id1, e_v0, e_v1, e_q0, e_q1, bk0, bk1;
    bit bad;
    e_id0 = 0; e_id1 = 0; e_v0 = 0; e_v1 = 0; bk0 = 1 << 30; bk1 = 1 << 30;
    for (int t = 0; t < N; t++) begin
      int k;
      if (icm[t]) continue;
      k = rank_of(t) * N + ((t - m_ptr + N) % N);
      if (k < bk0) begin
        bk1 = bk0; e_id1 = e_id0; e_v1 = e_v0;
        bk0 = k; e_id0 = t; e_v0 = 1;
      end else if (k < bk1) begin
        bk1 = k; e_id1 = t; e_v1 = 1;
      end
    end
    if (mode == 2'd0) e_v1 = 0;
    e_q0 = !e_v0 ? 0 : (e_v1 ? 4 : 8);
    e_q1 = e_v1 ? 4 : 0;
    bad = (int'(v0) != e_v0) || (int'(v1) != e_v1) || (int'(q0) != e_q0) || (int'(q1) != e_q1) ||
          (e_v0 && int'(id0) != e_id0) || (e_v1 && int'(id1) != e_id1);
    n_chk++;
    if (bad) begin
      n_fail++;
      $display("FAIL %s: got v0=%0d id0=%0d q0=%0d v1=%0d id1=%0d q1=%0d exp v0=%0d id0=%0d q0=%0d v1=%0d id1=%0d q1=%0d",
               tag, v0, id0, q0, v1, id1, q1, e_v0, e_id0, e_q0, e_v1, e_id1, e_q1);
    end
  endtask

  task automatic check_eq(string t, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d exp %0d", t, got, exp);
    end
  endtask

  // inputs are set at negedge; outputs sampled 1ns later; model follows the posedge
  task automatic step();
    #1 check_now();
    @(posedge clk);
    for (int t = 0; t < N; t++) begin
      m_ic[t] = clampc(m_ic[t] + int'(fetch[t]) - int'(issue[t]) - int'(squash[t]));
      m_br[t] = clampc(m_br[t] + int'(brf[t]) - int'(brr[t]));
      m_ms[t] = clampc(m_ms[t] + int'(dms[t]) - int'(dmd[t]));
    end
    m_ptr = (m_ptr + 1) % N;
    @(negedge clk);
  endtask

  task automatic rand_pulses(int m);
    fetch = 8'($urandom) & 8'($urandom);
    issue = 8'($urandom) & 8'($urandom);
    squash = 8'($urandom) & 8'($urandom) & 8'($urandom);
    brf = 8'($urandom) & 8'($urandom);
    brr = 8'($urandom) & 8'($urandom);
    dms = 8'($urandom) & 8'($urandom);
    dmd = 8'($urandom) & 8'($urandom);
    icm = (($urandom % 16) == 0) ? 8'hFF : (8'($urandom) & 8'($urandom));
    mode = 2'(m);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int t = 0; t < N; t++) begin m_ic[t] = 0; m_br[t] = 0; m_ms[t] = 0; end
    m_ptr = 0;
    clear_in();
    mode = 2'd1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1: reset state, ties from pointer 0
    tag = "R1";
    #1;
    check_eq("R1 id0", int'(id0), 0);
    check_eq("R1 id1", int'(id1), 1);
    check_eq("R1 quotas", int'(q0) * 16 + int'(q1), 4 * 16 + 4);
    step();

    // R2/R9: rotation grants one thread per cycle, pointer steps by one
    tag = "R2"; mode = 2'd0;
    for (int c = 0; c < 10; c++) begin
      #1 check_eq("R2 rr id", int'(id0), m_ptr);
      check_eq("R9 rr quota", int'(q0), 8);
      step();
    end
    tag = "R9";
    for (int c = 0; c < 12; c++) begin icm = 8'($urandom); step(); end
    icm = '0;

    // R12: equal counts ordered from the pointer
    tag = "R12"; mode = 2'd1;
    for (int c = 0; c < 8; c++) step();

    // R8: threads with instruction cache miss skipped
    tag = "R8";
    for (int c = 0; c < 20; c++) begin icm = 8'($urandom); step(); end

    // R11: none eligible, then only thread 5
    tag = "R11";
    icm = 8'hFF; step();
    icm = ~8'h20; step();
    #1 check_eq("R11 lone id", int'(id0), 5);
    check_eq("R11 lone quota", int'(q0), 8);
    check_eq("R11 slot1 vld", int'(v1), 0);
    icm = '0;

    // R13: pulse in cycle N seen only in N+1
    tag = "R13";
    fetch = 8'h01; step();
    fetch = '0;
    #1 check_eq("R13 thread0 demoted", int'(id0 == 3'd0 || id1 == 3'd0), 0);
    step();
    issue = 8'h01; step();
    issue = '0; step();

    // R3: saturate high then low on thread 0
    tag = "R3";
    fetch = 8'h01;
    for (int c = 0; c < 135; c++) step();
    fetch = '0; issue = 8'h01; squash = 8'h01;
    for (int c = 0; c < 70; c++) step();
    issue = '0; squash = '0;
    fetch = 8'h0F;
    for (int c = 0; c < 130; c++) begin fetch[0] = c[0]; step(); end
    fetch = 8'h0F;
    issue = 8'h03;
    for (int c = 0; c < 20; c++) step();
    clear_in();

    // R4: simultaneous increment and decrement
    tag = "R4";
    for (int c = 0; c < 60; c++) begin
      fetch = 8'($urandom); issue = 8'($urandom); squash = 8'($urandom) & 8'($urandom);
      step();
    end
    clear_in();

    // R5, R6, R7, R10: each counter policy under random traffic
    for (int m = 1; m < 4; m++) begin
      tag = (m == 1) ? "R5" : (m == 2) ? "R6" : "R7";
      for (int c = 0; c < 250; c++) begin rand_pulses(m); icm = '0; step(); end
    end
    tag = "R10";
    for (int c = 0; c < 40; c++) begin rand_pulses(1 + (c % 3)); icm = 8'($urandom) & 8'h7F; step(); end

    // mixed policies, mixed eligibility
    for (int blk = 0; blk < 80; blk++) begin
      int m;
      m = int'($urandom % 4);
      tag = (m == 0) ? "R9" : (m == 1) ? "R5" : (m == 2) ? "R6" : "R7";
      for (int c = 0; c < 40; c++) begin rand_pulses(m); step(); end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule